// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block holds the modem status byte of one UART channel. It watches four active-low handshake lines from the attached modem: carrier detect, ring indicator, data set ready and clear to send. Each line passes through a synchronizer, and the block reports the line as an active-high level bit. Beside each level bit sits a sticky change flag. The flag records that the line moved since the processor last read the byte.

A read strobe returns the whole byte and clears the four change flags in the same cycle. A change that lands in the same cycle as the read is still kept. When loopback is enabled, the four level bits come from bits of the modem control register instead of the pins. Change detection always follows whichever source is selected. A modem-status interrupt request is raised while any change flag is set and the interrupt enable input is high.

Top module: `modem_status_reg`

## Requirements
- R1: In normal mode each level bit is the inverse of its pin after a two-flop synchronizer. A pin change appears in `rd_data` two rising edges after it is applied. The level bit positions are: bit 7 carrier, bit 6 ring, bit 5 data set ready, bit 4 clear to send.
- R2: The change flags sit in `rd_data` at bit 3 (carrier), bit 2 (ring), bit 1 (data set ready) and bit 0 (clear to send). Each flag becomes set on the clock edge that follows the qualifying change of its selected level bit.
- R3: The carrier, data set ready and clear to send flags are set by a change of the selected level in either direction.
- R4: The ring flag is set only when the ring pin goes from low to high, which is when its level bit falls from 1 to 0. In loopback it is set only when control bit 2 falls from 1 to 0. A rise of the ring level sets no flag.
- R5: During a read-strobe cycle, `rd_data` shows the flags as they were before the clear. All four flags are zero after that edge, unless R6 applies.
- R6: A qualifying change that happens in the same cycle as a read leaves its flag set after the read.
- R7: With loopback enabled, the level bits are taken from the control bits as follows: carrier from bit 3, ring from bit 2, data set ready from bit 0, clear to send from bit 1. The pins then have no effect on `rd_data`.
- R8: `ms_irq` is high exactly when `ms_irq_en` is high and at least one change flag is set.
- R9: After a synchronous active-high reset, all flags are zero. The synchronizers and the change history are loaded from the current inputs, so steady inputs raise no flag after reset.
- R10: Entering or leaving loopback sets the flag of every line whose selected level differs across the switch, subject to the edge rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cd_n | input | 1 | Carrier detect pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dsr_n | input | 1 | Data set ready pin, active low |
| cts_n | input | 1 | Clear to send pin, active low |
| mcr_i | input | 4 | Modem control bits used as sources in loopback |
| loop_en | input | 1 | Selects control bits instead of pins |
| rd_stb | input | 1 | One-cycle read of the status byte; clears the flags |
| rd_data | output | 8 | Status byte: levels in bits 7..4, flags in bits 3..0 |
| ms_irq_en | input | 1 | Modem-status interrupt enable |
| ms_irq | output | 1 | Modem-status interrupt request |

## Verification
The bench drives the ring line in both directions. A design that flags the leading edge of a ring, or one that treats ring like the other three lines, returns a wrong bit 2. A pulse on data set ready that goes out and comes back before a read must still leave its flag set; a design that compares levels only at read time would lose it. The bench places a loopback control change in the very cycle of a read. A design that lets the clear win drops that event, and a design that returns post-clear data shows the flag too early. Switching loopback on and off with differing sources, moving pins while loopback is active, and crossing the loopback control map all expose a wrong source selection or a wrong bit mapping.

// File: rtl/msr_pkg.sv
package msr_pkg;

   // Line index doubles as the change-flag bit position; level bit is index + NUM_LINES.
   localparam int NUM_LINES = 4;
   localparam int LN_CTS    = 0;
   localparam int LN_DSR    = 1;
   localparam int LN_RI     = 2;
   localparam int LN_CD     = 3;

   // Which transition of the active-high level raises a line's change flag.
   typedef enum logic {
      DET_BOTH,   // any level change
      DET_TRAIL   // level 1 -> 0 only (pin low -> high)
   } det_kind_e;

   // Control bit feeding each line while loopback is active.
   function automatic int lb_src_bit(input int ln);
      case (ln)
         LN_CTS:  return 1;
         LN_DSR:  return 0;
         LN_RI:   return 2;
         default: return 3;
      endcase
   endfunction

   function automatic det_kind_e line_kind(input int ln);
      return (ln == LN_RI) ? DET_TRAIL : DET_BOTH;
   endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("msr_sync: STAGES must be 2..4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("msr_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            stage_q[s] <= async_i;   // seed with current pin level
         end else if (s == 0) begin
            stage_q[s] <= async_i;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/msr_delta_line.sv
module msr_delta_line
   import msr_pkg::*;
#(
   parameter det_kind_e KIND = DET_BOTH
) (
   input  logic clk,
   input  logic rst,
   input  logic cur_i,    // selected active-high level
   input  logic seed_i,   // level loaded into history at reset
   input  logic clr_i,    // read strobe
   output logic flag_o
);

   logic prev_q;
   logic flag_q;
   logic evt;

   if (KIND == DET_BOTH) begin : g_both
      assign evt = cur_i ^ prev_q;
   end else begin : g_trail
      assign evt = prev_q & ~cur_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q <= seed_i;
         flag_q <= 1'b0;
      end else begin
         prev_q <= cur_i;
         flag_q <= (flag_q & ~clr_i) | evt;
      end
   end

   assign flag_o = flag_q;

   AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
      evt |=> flag_q); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flag_q && !clr_i) |=> flag_q); // R5

   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (clr_i && !evt) |=> !flag_q); // R5

   AST_STEADY_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
      (!flag_q && cur_i == prev_q) |=> !flag_q); // R9

   if (KIND == DET_TRAIL) begin : g_trail_chk
      AST_RISE_IGNORED: assert property (@(posedge clk) disable iff (rst)
         (!flag_q && cur_i && !prev_q) |=> !flag_q); // R4
   end

endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
   import msr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cd_n,
   input  logic       ri_n,
   input  logic       dsr_n,
   input  logic       cts_n,
   input  logic [3:0] mcr_i,
   input  logic       loop_en,
   input  logic       rd_stb,
   output logic [7:0] rd_data,
   input  logic       ms_irq_en,
   output logic       ms_irq
);

   localparam int NL = NUM_LINES;

   if (NL != 4) begin : g_bad_lines
      $error("modem_status_reg: four modem lines expected");
   end

   logic [NL-1:0] pin_n;
   logic [NL-1:0] pin_sync_n;
   logic [NL-1:0] level;
   logic [NL-1:0] seed;
   logic [NL-1:0] flag;

   // Pack pins in line-index order.
   assign pin_n[LN_CD]  = cd_n;
   assign pin_n[LN_RI]  = ri_n;
   assign pin_n[LN_DSR] = dsr_n;
   assign pin_n[LN_CTS] = cts_n;

   msr_sync #(
      .WIDTH  (NL),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk     (clk),
      .rst     (rst),
      .async_i (pin_n),
      .sync_o  (pin_sync_n)
   );

   for (genvar g = 0; g < NL; g++) begin : g_line
      localparam int CB = lb_src_bit(g);

      assign level[g] = loop_en ? mcr_i[CB] : ~pin_sync_n[g];
      assign seed[g]  = loop_en ? mcr_i[CB] : ~pin_n[g];

      msr_delta_line #(
         .KIND (line_kind(g))
      ) line_i (
         .clk    (clk),
         .rst    (rst),
         .cur_i  (level[g]),
         .seed_i (seed[g]),
         .clr_i  (rd_stb),
         .flag_o (flag[g])
      );
   end

   assign rd_data = {level, flag};
   assign ms_irq  = ms_irq_en & (|flag);

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
      (rd_data[3:0] == 4'b0000) |-> !ms_irq); // R8

   AST_LOOP_CD_SRC: assert property (@(posedge clk) disable iff (rst)
      loop_en |-> (rd_data[7] == mcr_i[3])); // R7

   AST_LOOP_DSR_SRC: assert property (@(posedge clk) disable iff (rst)
      loop_en |-> (rd_data[5] == mcr_i[0])); // R7

   AST_LOOP_PIN_BLIND: assert property (@(posedge clk) disable iff (rst)
      (loop_en && $past(loop_en) && $stable(mcr_i)) |-> $stable(rd_data[7:4])); // R7

endmodule

// File: tb/modem_status_reg_tb_top.sv
module modem_status_reg_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst;
   logic       cd_n, ri_n, dsr_n, cts_n;
   logic [3:0] mcr_i;
   logic       loop_en;
   logic       rd_stb;
   logic [7:0] rd_data;
   logic       ms_irq_en;
   logic       ms_irq;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   modem_status_reg dut_i (
      .clk       (clk),
      .rst       (rst),
      .cd_n      (cd_n),
      .ri_n      (ri_n),
      .dsr_n     (dsr_n),
      .cts_n     (cts_n),
      .mcr_i     (mcr_i),
      .loop_en   (loop_en),
      .rd_stb    (rd_stb),
      .rd_data   (rd_data),
      .ms_irq_en (ms_irq_en),
      .ms_irq    (ms_irq)
   );

   task automatic tally(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // Driver: queue the expected byte, then strobe one read cycle.
   task automatic rd(input logic [7:0] e, input string req);
      @(negedge clk);
      exp_q.push_back(e);
      tag_q.push_back(req);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_irq(input logic e, input string req);
      @(negedge clk);
      #(CLK_P/4);
      tally(ms_irq === e, req, int'(ms_irq), int'(e));
   endtask

   // Monitor: compare every read cycle against the scoreboard queue.
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_P/4);
         if (rd_stb === 1'b1) begin
            if (exp_q.size() == 0) begin
               tally(1'b0, "scoreboard-empty", int'(rd_data), 0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               tally(rd_data === e, t, int'(rd_data), int'(e));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 0x00 expected 0x01");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; rd_stb = 1'b0; loop_en = 1'b0; mcr_i = 4'h0; ms_irq_en = 1'b1;
      cd_n = 1'b0; ri_n = 1'b1; dsr_n = 1'b1; cts_n = 1'b1;
      idle(4);
      rst = 1'b0;

      // R9: carrier present at reset, no spurious flag
      idle(4);
      chk_irq(1'b0, "R9 irq after reset");
      rd(8'h80, "R9 reset state");

      // R1: level appears two edges after the pin moves
      @(negedge clk);
      cts_n = 1'b0;
      @(negedge clk);
      #(CLK_P/4);
      tally(rd_data[4] === 1'b0, "R1 sync stage one", int'(rd_data[4]), 0);
      @(negedge clk);
      #(CLK_P/4);
      tally(rd_data[4] === 1'b1, "R1 sync stage two", int'(rd_data[4]), 1);
      idle(2);
      chk_irq(1'b1, "R8 irq on flag");
      rd(8'h91, "R2 cts flag bit0");
      rd(8'h90, "R5 cleared by read");
      chk_irq(1'b0, "R8 irq drops");

      // R4: ring start sets no flag, ring end does
      ri_n = 1'b0;
      idle(4);
      rd(8'hD0, "R4 ring start no flag");
      ri_n = 1'b1;
      idle(4);
      rd(8'h94, "R4 ring end flag");
      rd(8'h90, "R5 ring flag cleared");

      // R3: pulse out and back still flagged
      dsr_n = 1'b0;
      idle(4);
      dsr_n = 1'b1;
      idle(4);
      rd(8'h92, "R3 dsr pulse");
      cd_n = 1'b1;
      idle(4);
      rd(8'h18, "R3 carrier loss");

      // R8: enable gating
      ms_irq_en = 1'b0;
      cts_n = 1'b1;
      idle(4);
      chk_irq(1'b0, "R8 irq masked");
      ms_irq_en = 1'b1;
      chk_irq(1'b1, "R8 irq unmasked");
      rd(8'h01, "R3 cts drop");

      // R7 / R10: loopback
      @(negedge clk);
      mcr_i = 4'h0; loop_en = 1'b1;
      idle(2);
      rd(8'h00, "R10 equal sources no flag");
      mcr_i = 4'b1000; idle(1);
      rd(8'h88, "R7 carrier from bit3");
      mcr_i = 4'b0001; idle(1);
      rd(8'h2A, "R7 dsr from bit0");
      mcr_i = 4'b0010; idle(1);
      rd(8'h13, "R7 cts from bit1");
      mcr_i = 4'b0100; idle(1);
      rd(8'h41, "R4 loop ring rise no flag");
      mcr_i = 4'b0000; idle(1);
      rd(8'h04, "R4 loop ring fall flag");
      cd_n = 1'b0;
      idle(4);
      rd(8'h00, "R7 pins ignored");
      @(negedge clk);
      loop_en = 1'b0;
      idle(1);
      rd(8'h88, "R10 leave loopback");
      rd(8'h80, "R5 cleared after switch");

      // R6: event in the read cycle survives the clear
      @(negedge clk);
      mcr_i = 4'b1000; loop_en = 1'b1;
      idle(2);
      rd(8'h80, "R10 same level no flag");
      @(negedge clk);
      exp_q.push_back(8'h00);
      tag_q.push_back("R5 pre-clear data in collision");
      mcr_i = 4'b0000;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      rd(8'h08, "R6 flag kept through read");
      rd(8'h00, "R6 flag cleared afterwards");

      idle(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule